// File: doc/BRIEF.md
# Calibration Trigger Sequencer

This block decides when an on-command self-calibration may begin and then holds a running indication for the length of that calibration. The request comes from two places, a pin and a register bit, and the block treats it as one signal by OR-ing them. A calibration is launched only after a clean low-then-high shape on that combined request: it must first stay low for at least `LOW_MIN` consecutive clock cycles, which arms the block, and must then stay high for at least `HIGH_MIN` consecutive cycles.

Once launched, the block raises `cal_run` for exactly `RUN_CYCLES` cycles and gives a one-cycle `cal_start` pulse in the first of them. The analog calibration steps themselves are not part of this block. A request still high when the run ends does not start a second run. The combined request must go low for the full minimum time again first, so the pin and the bit must both be released. A power-down input aborts a run at once and clears all arming.

Top module: `cal_trigger_seq`

## Requirements
- R1: The effective request is cal_pin OR cal_bit. Either source alone, given a valid low-then-high shape, launches a run.
- R2: A run launches only after the request has been low for at least LOW_MIN consecutive cycles and then high for at least HIGH_MIN consecutive cycles. cal_run is first seen high right after the clock edge that samples the HIGH_MIN-th high cycle.
- R3: cal_start is high for exactly one cycle per run, in the first cycle in which cal_run is high.
- R4: cal_run stays high for exactly RUN_CYCLES consecutive cycles, then goes low, unless power-down cuts the run short.
- R5: A high phase shorter than HIGH_MIN launches nothing and discards the arming. A further full LOW_MIN low phase is needed before a launch.
- R6: A request still high when a run ends does not launch again until it has been low for LOW_MIN cycles. While either source stays high, the block stays disarmed.
- R7: While pwr_down is high, cal_run is low from the next cycle on and nothing launches. Arming is cleared, so a request still high after power-down is released does not launch.
- R8: After reset, cal_run and cal_start are low and the block is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_pin | input | 1 | Calibrate request from the pin |
| cal_bit | input | 1 | Calibrate request from the control register bit |
| pwr_down | input | 1 | Power-down; aborts a run and clears arming |
| cal_run | output | 1 | High while a calibration run is in progress |
| cal_start | output | 1 | One-cycle pulse at the start of a run |

## Verification
The hardest state to reach is one where the block has just been armed and then loses that arming. This happens through a high phase one cycle short of HIGH_MIN, or through one source still high after the other drops. The stimulus sweeps every low length from zero to LOW_MIN+1 against every high length from one to HIGH_MIN+1, starting each trial from power-down. It then runs directed sequences that arm the block, send a short pulse, and try to launch without a fresh low phase. Other sequences hold the register bit high across a run while the pin toggles, and cut a run short with power-down while the request stays high.

// File: rtl/cal_trigger_seq.sv
module cal_trigger_seq #(
  parameter int LOW_MIN    = 4,
  parameter int HIGH_MIN   = 3,
  parameter int RUN_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_pin,
  input  logic cal_bit,
  input  logic pwr_down,
  output logic cal_run,
  output logic cal_start
);

  localparam int LW = $clog2(LOW_MIN + 1);
  localparam int HW = $clog2(HIGH_MIN + 1);
  localparam int RW = $clog2(RUN_CYCLES + 1);
  localparam logic [LW-1:0] LO_FULL  = LW'(LOW_MIN);
  localparam logic [HW-1:0] HI_LAST  = HW'(HIGH_MIN - 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_CYCLES - 1);

  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t        state;
  logic [LW-1:0] lo_cnt;
  logic [HW-1:0] hi_cnt;
  logic [RW-1:0] run_cnt;
  logic          req;
  logic          armed;

  assign req     = cal_pin | cal_bit;
  assign armed   = (lo_cnt == LO_FULL);
  assign cal_run = (state == S_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_down) begin
      state     <= S_IDLE;
      lo_cnt    <= '0;
      hi_cnt    <= '0;
      run_cnt   <= '0;
      cal_start <= 1'b0;
    end else begin
      cal_start <= 1'b0;
      case (state)
        S_IDLE: begin
          if (!req) begin
            hi_cnt <= '0;
            if (hi_cnt != '0)
              lo_cnt <= LW'(1);
            else if (!armed)
              lo_cnt <= lo_cnt + 1'b1;
          end else if (armed) begin
            if (hi_cnt == HI_LAST) begin
              state     <= S_RUN;
              cal_start <= 1'b1;
              lo_cnt    <= '0;
              hi_cnt    <= '0;
              run_cnt   <= '0;
            end else begin
              hi_cnt <= hi_cnt + 1'b1;
            end
          end else begin
            lo_cnt <= '0;
            hi_cnt <= '0;
          end
        end
        default: begin
          if (run_cnt == RUN_LAST) begin
            state   <= S_IDLE;
            run_cnt <= '0;
          end else begin
            run_cnt <= run_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  p_start_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);

  p_start_in_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> cal_run);

  p_rise_has_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_run) |-> cal_start);

  p_launch_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> ($past(req) && $past(armed) && !$past(pwr_down)));

  p_run_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_run && run_cnt != RUN_LAST && !pwr_down) |=> cal_run);

  p_run_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_run && run_cnt == RUN_LAST) |=> !cal_run);

  p_pd_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (!cal_run && !cal_start));

  p_no_arm_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_run |-> (lo_cnt == '0));

  always_comb begin
    if (rst_n) p_lo_bound_r2: assert (lo_cnt <= LO_FULL);
  end

endmodule

// File: tb/tb_cal_trigger_seq.sv
module tb_cal_trigger_seq;
  localparam int L = 4;
  localparam int H = 3;
  localparam int R = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_pin = 1'b0, cal_bit = 1'b0, pwr_down = 1'b0;
  logic cal_run, cal_start;

  int total = 0, bad = 0;
  int n_run = 0, n_start = 0, first_run = -1, cyc_idx = 0;
  bit done = 1'b0;

  cal_trigger_seq #(.LOW_MIN(L), .HIGH_MIN(H), .RUN_CYCLES(R)) dut (
    .clk(clk), .rst_n(rst_n), .cal_pin(cal_pin), .cal_bit(cal_bit),
    .pwr_down(pwr_down), .cal_run(cal_run), .cal_start(cal_start));

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    n_run = 0; n_start = 0; first_run = -1; cyc_idx = 0;
  endtask

  task automatic cyc(input logic p, input logic b, input logic d);
    cal_pin = p; cal_bit = b; pwr_down = d;
    @(posedge clk); #1;
    cyc_idx++;
    if (cal_run) begin
      n_run++;
      if (first_run < 0) first_run = cyc_idx;
    end
    if (cal_start) begin
      n_start++;
      if (!cal_run) check("R3 start outside run", 1, 0);
    end
  endtask

  task automatic reps(input int n, input logic p, input logic b, input logic d);
    for (int i = 0; i < n; i++) cyc(p, b, d);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    reps(3, 1'b1, 1'b1, 1'b0);
    check("R8 reset run", int'(cal_run), 0);
    check("R8 reset start", int'(cal_start), 0);
    rst_n = 1'b1;
    clr();
    reps(H + 2, 1'b1, 1'b0, 1'b0);
    check("R8 disarmed after reset", n_run, 0);

    for (int l = 0; l <= L + 1; l++) begin
      for (int h = 1; h <= H + 1; h++) begin
        logic usepin;
        bit expect_go;
        usepin = ((l + h) % 2) == 0;
        expect_go = (l >= L) && (h >= H);
        reps(2, 1'b0, 1'b0, 1'b1);
        clr();
        reps(l, 1'b0, 1'b0, 1'b0);
        cyc_idx = 0;
        reps(h, usepin, !usepin, 1'b0);
        reps(R + 3, 1'b0, 1'b0, 1'b0);
        check($sformatf("R2 sweep l=%0d h=%0d run", l, h), n_run, expect_go ? R : 0);
        check($sformatf("R3 sweep l=%0d h=%0d start", l, h), n_start, expect_go ? 1 : 0);
        if (expect_go)
          check($sformatf("R2 rise l=%0d h=%0d", l, h), first_run, H);
        if (expect_go && !usepin)
          check("R1 bit alone launches", n_start, 1);
      end
    end

    reps(2, 1'b0, 1'b0, 1'b1);
    clr();
    reps(L, 1'b0, 1'b0, 1'b0);
    reps(H - 1, 1'b1, 1'b0, 1'b0);
    reps(1, 1'b0, 1'b0, 1'b0);
    reps(H + 2, 1'b1, 1'b0, 1'b0);
    check("R5 short pulse drops arming", n_run, 0);
    reps(L, 1'b0, 1'b0, 1'b0);
    cyc_idx = 0; first_run = -1;
    reps(H + R + 2, 1'b1, 1'b0, 1'b0);
    check("R5 launch after fresh low", n_start, 1);
    check("R4 run length", n_run, R);
    check("R2 rise after rearm", first_run, H);
    check("R6 held high no retrigger", n_start, 1);

    reps(2, 1'b0, 1'b0, 1'b1);
    clr();
    reps(L, 1'b0, 1'b0, 1'b0);
    reps(H, 1'b1, 1'b1, 1'b0);
    reps(R, 1'b0, 1'b1, 1'b0);
    check("R6 first run", n_start, 1);
    reps(L + 1, 1'b0, 1'b1, 1'b0);
    reps(H + 1, 1'b1, 1'b1, 1'b0);
    reps(L + 1, 1'b0, 1'b1, 1'b0);
    check("R6 bit high keeps disarmed", n_start, 1);
    reps(L, 1'b0, 1'b0, 1'b0);
    reps(H + R + 1, 1'b1, 1'b0, 1'b0);
    check("R1 R6 rearm then pin launches", n_start, 2);

    reps(2, 1'b0, 1'b0, 1'b1);
    clr();
    reps(L, 1'b0, 1'b0, 1'b0);
    reps(H + 3, 1'b1, 1'b0, 1'b0);
    check("R7 run active before pd", int'(cal_run), 1);
    cyc(1'b1, 1'b0, 1'b1);
    check("R7 pd drops run", int'(cal_run), 0);
    n_run = 0;
    reps(R + H + 2, 1'b1, 1'b0, 1'b0);
    check("R7 no relaunch after pd", n_run, 0);
    reps(L, 1'b0, 1'b0, 1'b0);
    reps(H, 1'b1, 1'b0, 1'b1);
    check("R7 pd blocks launch", n_run, 0);
    reps(L, 1'b0, 1'b0, 1'b0);
    cyc_idx = 0; first_run = -1;
    reps(H + R + 2, 1'b0, 1'b1, 1'b0);
    check("R7 launch after pd released", n_run, R);
    check("R2 rise after pd", first_run, H);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule